// File: doc/BRIEF.md
# SD Data Path Suspend Controller

This block sequences the data side of an SD/SDIO host through writes, reads, suspend and read-wait. Software arms it with an enable bit and a start pulse that carries the direction. The command side supplies a one-cycle pulse when the card has acknowledged a suspend command. The data line model gives a pulse at the end of each block and a serial CRC status token on data line 0. The receive FIFO supplies its empty flag.

A suspended write stops at the CRC status token of the block in flight. A suspended read takes one final packet from the card, then waits until the FIFO has been read dry. The block does not remember how many blocks were left, so a resume starts a fresh transfer. While the card clock is held for read-wait, a low level on data line 1 is latched as a sticky SDIO interrupt, but only in SDIO mode.

Top module: `sd_dpath_suspend`

## Requirements
- R1: After reset the state output is Idle (code 0), and crc_fail and sdio_irq are low.
- R2: In Idle with enable high, a start pulse moves to Send (code 1) when dir_rd is 0, or to Wait_r (code 3) when dir_rd is 1.
- R3: A blk_done pulse in Send moves to Busy (code 2). Busy reads a token on d0: a start bit 0, three status bits sent MSB first, then an end bit 1. In the cycle after the end bit, a token with status 010 and end bit 1 returns to Send when no suspend is pending.
- R4: A suspend_ack during a write (Send or Busy) lets the current block and its token finish, then goes to Idle instead of Send. No count of remaining blocks is kept, and the next start begins in Send.
- R5: A token whose status is not 010, or whose end bit is 0, sets crc_fail and goes to Idle. crc_fail stays set until the next accepted start.
- R6: Enable low moves the state to Idle on the next clock from any state.
- R7: A suspend_ack while Idle is ignored, and the state stays Idle.
- R8: In Wait_r, d0 low (start bit) moves to Receive (code 4). A blk_done pulse in Receive returns to Wait_r.
- R9: After a suspend_ack in a read, one more packet is received. Wait_r then ignores d0 and rw_req, and goes to Idle in the cycle after fifo_empty is high.
- R10: In Wait_r with no final packet pending, rw_req high moves to ReadWait (code 5). rw_req low in ReadWait returns to Wait_r.
- R11: d1 low while in ReadWait with sdio_mode high sets sdio_irq, and it stays set. With sdio_mode low, d1 has no effect.
- R12: irq_clr clears sdio_irq on the next clock. A new interrupt in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dp_en | input | 1 | Data path enable from software |
| start | input | 1 | Start pulse for a transfer |
| dir_rd | input | 1 | Direction at start: 1 read, 0 write |
| blk_done | input | 1 | End of block on the data lines |
| suspend_ack | input | 1 | Card accepted a suspend command |
| rw_req | input | 1 | Hold read-wait (card clock stopped) |
| sdio_mode | input | 1 | Enable SDIO interrupt sampling |
| d0 | input | 1 | Data line 0 (start bits, CRC token) |
| d1 | input | 1 | Data line 1 (interrupt level) |
| fifo_empty | input | 1 | Receive FIFO is empty |
| irq_clr | input | 1 | Write-one-to-clear for sdio_irq |
| state | output | 3 | Data path state code |
| crc_fail | output | 1 | Last CRC status token was rejected |
| sdio_irq | output | 1 | Sticky SDIO interrupt flag |

## Verification
The hardest situation to reach is a read suspend that drains cleanly. It needs a suspend acknowledge while reading, then the one extra packet, then Wait_r held with d0 low and fifo_empty low, and only then the drain. Random inputs almost never line up in that order, so a directed sequence builds it step by step, and a random phase with a cycle model then covers how it mixes with read-wait and disable. Tokens are shifted bit by bit, both accepted and corrupted, so that Busy exits are seen on both paths.

// File: rtl/sd_dpath_suspend.sv
module sd_dpath_suspend #(
  parameter logic [2:0] TOK_OK = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp_en,
  input  logic       start,
  input  logic       dir_rd,
  input  logic       blk_done,
  input  logic       suspend_ack,
  input  logic       rw_req,
  input  logic       sdio_mode,
  input  logic       d0,
  input  logic       d1,
  input  logic       fifo_empty,
  input  logic       irq_clr,
  output logic [2:0] state,
  output logic       crc_fail,
  output logic       sdio_irq
);
  localparam logic [2:0] IDLE = 3'd0, SEND = 3'd1, BUSY = 3'd2,
                         WAITR = 3'd3, RECV = 3'd4, RWAIT = 3'd5;

  logic [2:0] nxt, tok, cnt;
  logic       susp, rd_final;

  wire tok_end  = (state == BUSY) && (cnt == 3'd4);
  wire tok_good = (tok == TOK_OK) && d0;
  wire go       = (state == IDLE) && start && dp_en;
  wire irq_hit  = sdio_mode && (state == RWAIT) && !d1;

  always_comb begin
    nxt = state;
    case (state)
      IDLE:  if (start) nxt = dir_rd ? WAITR : SEND;
      SEND:  if (blk_done) nxt = BUSY;
      BUSY:  if (tok_end) nxt = (!tok_good || susp) ? IDLE : SEND;
      WAITR: begin
        if (rd_final) begin
          if (fifo_empty) nxt = IDLE;
        end else if (rw_req) nxt = RWAIT;
        else if (!d0) nxt = RECV;
      end
      RECV:  if (blk_done) nxt = WAITR;
      RWAIT: if (!rw_req) nxt = WAITR;
      default: nxt = IDLE;
    endcase
    if (!dp_en) nxt = IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IDLE;
      cnt      <= '0;
      tok      <= '0;
      susp     <= 1'b0;
      rd_final <= 1'b0;
      crc_fail <= 1'b0;
      sdio_irq <= 1'b0;
    end else begin
      state <= nxt;

      if (state != BUSY || tok_end) cnt <= '0;
      else if (cnt == 3'd0) begin
        if (!d0) cnt <= 3'd1;
      end else begin
        tok <= {tok[1:0], d0};
        cnt <= cnt + 3'd1;
      end

      if (nxt == IDLE) susp <= 1'b0;
      else if (suspend_ack && state != IDLE) susp <= 1'b1;

      if (nxt == IDLE) rd_final <= 1'b0;
      else if (state == RECV && blk_done && susp) rd_final <= 1'b1;

      if (go) crc_fail <= 1'b0;
      else if (tok_end && !tok_good) crc_fail <= 1'b1;

      if (irq_hit) sdio_irq <= 1'b1;
      else if (irq_clr) sdio_irq <= 1'b0;
    end
  end
endmodule

module sd_dpath_suspend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dp_en,
  input logic       start,
  input logic       blk_done,
  input logic       suspend_ack,
  input logic       sdio_mode,
  input logic       d1,
  input logic       irq_clr,
  input logic [2:0] state,
  input logic       crc_fail,
  input logic       sdio_irq
);
  // R7
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && suspend_ack && !start) |=> state == 3'd0);
  // R6
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_en |=> state == 3'd0);
  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdio_mode && !irq_clr) |=> $stable(sdio_irq));
  // R12
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !(sdio_mode && state == 3'd5 && !d1)) |=> !sdio_irq);
  // R5
  crc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_fail) |-> state == 3'd0);
  // R8
  recv_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd4 |=> (state == 3'd4 || state == 3'd3 || state == 3'd0));
  // R3
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1 && blk_done && dp_en) |=> state == 3'd2);
  // R2
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 3'd5);
endmodule

bind sd_dpath_suspend sd_dpath_suspend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dp_en(dp_en), .start(start), .blk_done(blk_done),
  .suspend_ack(suspend_ack), .sdio_mode(sdio_mode), .d1(d1), .irq_clr(irq_clr),
  .state(state), .crc_fail(crc_fail), .sdio_irq(sdio_irq)
);

// File: tb/tb_sd_dpath_suspend.sv
module tb_sd_dpath_suspend;
  localparam logic [2:0] IDLE = 3'd0, SEND = 3'd1, BUSY = 3'd2,
                         WAITR = 3'd3, RECV = 3'd4, RWAIT = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dp_en = 0, start = 0, dir_rd = 0, blk_done = 0, suspend_ack = 0;
  logic rw_req = 0, sdio_mode = 0, d0 = 1, d1 = 1, fifo_empty = 0, irq_clr = 0;
  logic [2:0] state;
  logic crc_fail, sdio_irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model of the requirements
  logic [2:0] m_st = IDLE, m_cnt = 0, m_tok = 0;
  logic m_susp = 0, m_fin = 0, m_fail = 0, m_irq = 0;

  sd_dpath_suspend dut (
    .clk(clk), .rst_n(rst_n), .dp_en(dp_en), .start(start), .dir_rd(dir_rd),
    .blk_done(blk_done), .suspend_ack(suspend_ack), .rw_req(rw_req),
    .sdio_mode(sdio_mode), .d0(d0), .d1(d1), .fifo_empty(fifo_empty),
    .irq_clr(irq_clr), .state(state), .crc_fail(crc_fail), .sdio_irq(sdio_irq)
  );

  always #5 clk = ~clk;

  function automatic logic [2:0] exp_next();
    logic [2:0] n = m_st;
    logic good = (m_tok == 3'b010) && d0;
    case (m_st)
      IDLE:  if (start) n = dir_rd ? WAITR : SEND;
      SEND:  if (blk_done) n = BUSY;
      BUSY:  if (m_cnt == 4) n = (good && !m_susp) ? SEND : IDLE;
      WAITR: if (m_fin) n = fifo_empty ? IDLE : WAITR;
             else if (rw_req) n = RWAIT;
             else if (!d0) n = RECV;
      RECV:  if (blk_done) n = WAITR;
      RWAIT: if (!rw_req) n = WAITR;
      default: n = IDLE;
    endcase
    if (!dp_en) n = IDLE;
    return n;
  endfunction

  task automatic model_step();
    logic [2:0] n = exp_next();
    logic tend = (m_st == BUSY) && (m_cnt == 4);
    logic good = (m_tok == 3'b010) && d0;
    if (m_st == IDLE && start && dp_en) m_fail = 0;
    else if (tend && !good) m_fail = 1;
    if (sdio_mode && m_st == RWAIT && !d1) m_irq = 1;
    else if (irq_clr) m_irq = 0;
    if (n == IDLE) begin m_susp = 0; m_fin = 0; end
    else begin
      if (m_st == RECV && blk_done && m_susp) m_fin = 1;
      if (suspend_ack && m_st != IDLE) m_susp = 1;
    end
    if (m_st != BUSY || tend) m_cnt = 0;
    else if (m_cnt == 0) begin if (!d0) m_cnt = 1; end
    else begin m_tok = {m_tok[1:0], d0}; m_cnt = m_cnt + 1; end
    m_st = n;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] s, input logic en);
    if (!en) return "R6";
    case (s)
      IDLE: return "R2"; SEND: return "R3"; BUSY: return "R5";
      WAITR: return "R9"; RECV: return "R8"; default: return "R11";
    endcase
  endfunction

  // one clock: model advances, outputs compared at the next falling edge
  task automatic cyc(input string req = "");
    string t = (req == "") ? tag_of(m_st, dp_en) : req;
    model_step();
    @(negedge clk);
    checks++;
    if (state !== m_st || crc_fail !== m_fail || sdio_irq !== m_irq) begin
      errors++;
      $display("FAIL %s actual=%0d/%0d/%0d expected=%0d/%0d/%0d", t,
               state, crc_fail, sdio_irq, m_st, m_fail, m_irq);
    end
    start = 0; blk_done = 0; suspend_ack = 0; irq_clr = 0;
  endtask

  task automatic token(input logic [2:0] st, input logic endb, input string req);
    d0 = 1; cyc(req);
    d0 = 0; cyc(req);
    for (int i = 2; i >= 0; i--) begin d0 = st[i]; cyc(req); end
    d0 = endb; cyc(req);
    d0 = 1;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5D1));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 state", state, IDLE); chk("R1 crc", crc_fail, 0); chk("R1 irq", sdio_irq, 0);
    rst_n = 1; dp_en = 1;
    // R7 suspend ack in Idle
    suspend_ack = 1; cyc("R7"); chk("R7", state, IDLE);
    // R2 R3 write with good token, continues
    start = 1; dir_rd = 0; cyc("R2"); chk("R2 write", state, SEND);
    blk_done = 1; cyc("R3"); chk("R3 busy", state, BUSY);
    token(3'b010, 1, "R3"); chk("R3 back to send", state, SEND);
    // R4 suspend during write
    suspend_ack = 1; cyc("R4");
    blk_done = 1; cyc("R4");
    token(3'b010, 1, "R4"); chk("R4 idle after token", state, IDLE);
    chk("R4 no crc", crc_fail, 0);
    start = 1; cyc("R4"); chk("R4 fresh start", state, SEND);
    // R5 bad token
    blk_done = 1; cyc("R5");
    token(3'b101, 1, "R5"); chk("R5 idle", state, IDLE); chk("R5 flag", crc_fail, 1);
    start = 1; cyc("R5"); chk("R5 cleared", crc_fail, 0);
    // R6 software abort of suspended write
    suspend_ack = 1; cyc("R6");
    dp_en = 0; cyc("R6"); chk("R6 idle", state, IDLE);
    dp_en = 1;
    // R8 R9 read suspend
    start = 1; dir_rd = 1; cyc("R2"); chk("R2 read", state, WAITR);
    d0 = 0; cyc("R8"); chk("R8 receive", state, RECV); d0 = 1;
    blk_done = 1; cyc("R8"); chk("R8 back", state, WAITR);
    suspend_ack = 1; cyc("R9");
    d0 = 0; cyc("R9"); d0 = 1; chk("R9 last packet", state, RECV);
    blk_done = 1; cyc("R9");
    d0 = 0; rw_req = 1; fifo_empty = 0;
    repeat (3) cyc("R9");
    chk("R9 holds", state, WAITR);
    d0 = 1; rw_req = 0; fifo_empty = 1; cyc("R9"); chk("R9 drained", state, IDLE);
    fifo_empty = 0;
    // R10 R11 R12 read wait
    start = 1; cyc("R10");
    rw_req = 1; cyc("R10"); chk("R10 readwait", state, RWAIT);
    sdio_mode = 0; d1 = 0; cyc("R11"); chk("R11 gated", sdio_irq, 0);
    sdio_mode = 1; cyc("R11"); chk("R11 set", sdio_irq, 1);
    d1 = 1; cyc("R11"); chk("R11 sticky", sdio_irq, 1);
    irq_clr = 1; d1 = 0; cyc("R12"); chk("R12 set wins", sdio_irq, 1);
    d1 = 1; irq_clr = 1; cyc("R12"); chk("R12 clear", sdio_irq, 0);
    rw_req = 0; cyc("R10"); chk("R10 resume", state, WAITR);
    // random phase against the model
    for (int i = 0; i < 6000; i++) begin
      dp_en       = ($urandom % 32) != 0;
      start       = ($urandom % 8) == 0;
      dir_rd      = $urandom % 2;
      blk_done    = ($urandom % 6) == 0;
      suspend_ack = ($urandom % 16) == 0;
      rw_req      = ($urandom % 5) == 0;
      sdio_mode   = $urandom % 2;
      d0          = ($urandom % 10) >= 3;
      d1          = $urandom % 2;
      fifo_empty  = ($urandom % 3) == 0;
      irq_clr     = ($urandom % 8) == 0;
      cyc();
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule